// File: doc/BRIEF.md
# DDR3 Command/Address Mirror and Parity Stage

This block is a single register stage placed between a DDR3 command scheduler and the DRAM command/address pins. Each cycle it takes one command bundle (row/column address, bank address, the RAS/CAS/WE strobes, per-rank chip selects, clock enables and on-die termination controls) and presents it on the pin side one clock later. When address mirroring is switched on, a command aimed at an odd-numbered rank has a fixed set of address and bank bit pairs swapped. This is needed because DIMMs route those pins crossed on the back side of the module.

For registered DIMMs the stage also produces an even parity bit over the address, bank and strobe pins. It computes this bit on the values actually driven, after any mirroring, and registers it together with the command it covers. The register on the DIMM reports parity faults on an open-drain, active-low return line. The stage synchronizes that line and records any fault in a sticky flag. Software clears the flag with a one-cycle clear pulse. A separate flag reports the illegal configuration in which parity is enabled while a nonzero control-adjust value is programmed.

Top module: `ddr3_ca_mirror_parity`

## Requirements
- R1: Every command output (chip selects, clock enables, termination controls, RAS/CAS/WE) equals the corresponding input of the previous clock cycle, unchanged.
- R2: With `cfg_mirror_en` high and chip select 1 or 3 asserted (active low, `in_cs_n[1]==0` or `in_cs_n[3]==0`), the registered address and bank show bank bits 0 and 1 swapped and address bit pairs 3/4, 5/6 and 7/8 swapped. All other bits pass unchanged.
- R3: With `cfg_mirror_en` low, or with neither chip select 1 nor 3 asserted, address and bank pass unchanged with one cycle of latency.
- R4: With `cfg_parity_en` high, `out_par` makes the XOR of `out_addr[15:0]`, `out_bank[2:0]`, `out_ras_n`, `out_cas_n`, `out_we_n` and `out_par` equal to zero (even parity), in the same cycle as the command it covers.
- R5: Chip selects, clock enables and termination controls have no influence on `out_par`.
- R6: With `cfg_parity_en` low, `out_par` is driven 0.
- R7: `par_err_n` passes through a two-flop synchronizer. A low sample taken while parity is enabled sets `par_err_sticky` at most three clock edges after the sample. The flag then stays set until cleared.
- R8: While `cfg_parity_en` is low, a low level on `par_err_n` does not set `par_err_sticky`.
- R9: A one-cycle `err_clr` pulse clears `par_err_sticky` at the next edge. A fault sample at the same edge takes priority, and the flag stays set.
- R10: `cfg_err` is high, one cycle later, exactly when `cfg_parity_en` is high and `cfg_ctl_adj` is nonzero.
- R11: While `rst` is high, all chip selects and strobes are driven high, address, bank, CKE, ODT and parity are driven 0, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_addr | input | 16 | Command address from the scheduler |
| in_bank | input | 3 | Bank address from the scheduler |
| in_ras_n | input | 1 | Row strobe, active low |
| in_cas_n | input | 1 | Column strobe, active low |
| in_we_n | input | 1 | Write strobe, active low |
| in_cs_n | input | 4 | Per-rank chip selects, active low |
| in_cke | input | 4 | Per-rank clock enables |
| in_odt | input | 4 | Per-rank termination controls |
| cfg_mirror_en | input | 1 | Enables odd-rank address/bank mirroring |
| cfg_parity_en | input | 1 | Enables parity generation and error capture |
| cfg_ctl_adj | input | 3 | Control-adjust setting, checked for conflict with parity |
| err_clr | input | 1 | Write-one-to-clear pulse for the sticky error flag |
| par_err_n | input | 1 | Open-drain parity error return, active low, asynchronous |
| out_addr | output | 16 | Address to the DRAM pins |
| out_bank | output | 3 | Bank address to the DRAM pins |
| out_ras_n | output | 1 | Registered row strobe |
| out_cas_n | output | 1 | Registered column strobe |
| out_we_n | output | 1 | Registered write strobe |
| out_cs_n | output | 4 | Registered chip selects |
| out_cke | output | 4 | Registered clock enables |
| out_odt | output | 4 | Registered termination controls |
| out_par | output | 1 | Even parity bit aligned with the command |
| par_err_sticky | output | 1 | Sticky parity error flag |
| cfg_err | output | 1 | Parity-with-control-adjust configuration error |

## Verification
The assertions check on every cycle the cycle-exact alignment of each command output with its input, the bit swaps or pass-through picked by the mirror condition, the even-parity relation on the driven pins, the zero parity bit when parity is off, the rule that the error flag only rises with parity enabled, its persistence and its clearing, and the configuration-error flag. Only the bench's scenarios can show the synchronizer's latency from a single low error sample, that a fault held low wins over a simultaneous clear, that a long fault seen while parity is off leaves nothing behind once parity is switched back on, and that toggling chip selects, CKE and ODT around a fixed command leaves the parity bit unchanged.

// File: rtl/ddr3_ca_pkg.sv
package ddr3_ca_pkg;
  // Address bit pairs crossed on the back side of a mirrored module (low index of each pair).
  localparam int MIR_PAIRS = 3;
  localparam int MIR_LO [MIR_PAIRS] = '{3, 5, 7};
  // Bank bit pair crossed on mirrored ranks.
  localparam int MIR_BANK_LO = 0;
  // Highest address bit touched by mirroring (for parameter sanity).
  localparam int MIR_ADDR_TOP = 8;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/ddr3_ca_mirror_map.sv
module ddr3_ca_mirror_map
  import ddr3_ca_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  parameter int RANKS  = 4
) (
  input  logic              mirror_en,
  input  logic [RANKS-1:0]  cs_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              mirrored
);
  logic [RANKS-1:0] odd_hit;

  // Only odd-numbered ranks sit on the crossed side of the module.
  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    if (r % 2 == 1) begin : g_odd
      assign odd_hit[r] = ~cs_n[r];
    end else begin : g_even
      assign odd_hit[r] = 1'b0;
    end
  end

  assign mirrored = mirror_en & (|odd_hit);

  always_comb begin
    addr_o = addr_i;
    bank_o = bank_i;
    if (mirrored) begin
      for (int p = 0; p < MIR_PAIRS; p++) begin
        addr_o[MIR_LO[p]]     = addr_i[MIR_LO[p] + 1];
        addr_o[MIR_LO[p] + 1] = addr_i[MIR_LO[p]];
      end
      bank_o[MIR_BANK_LO]     = bank_i[MIR_BANK_LO + 1];
      bank_o[MIR_BANK_LO + 1] = bank_i[MIR_BANK_LO];
    end
  end
endmodule

// File: rtl/ddr3_ca_parity_gen.sv
module ddr3_ca_parity_gen
  import ddr3_ca_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  input  strobe_t           strobes,
  output logic              par
);
  localparam int COV_W = ADDR_W + BANK_W + $bits(strobe_t);

  logic [COV_W-1:0] covered;

  // Chip selects, CKE and ODT are deliberately absent from the covered set.
  assign covered = {addr, bank, strobes};
  assign par     = enable & (^covered);
endmodule

// File: rtl/ddr3_ca_err_capture.sv
module ddr3_ca_err_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic clr,
  input  logic err_n_async,
  output logic sticky
);
  logic [SYNC_STAGES-1:0] sync_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b1;
        else     sync_q[s] <= err_n_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= 1'b1;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  logic hit;
  assign hit = enable & ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)      sticky <= 1'b0;
    else if (hit) sticky <= 1'b1;
    else if (clr) sticky <= 1'b0;
  end
endmodule

// File: rtl/ddr3_ca_mirror_parity.sv
module ddr3_ca_mirror_parity
  import ddr3_ca_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 3,
  parameter int RANKS       = 4,
  parameter int CADJ_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BANK_W-1:0] in_bank,
  input  logic              in_ras_n,
  input  logic              in_cas_n,
  input  logic              in_we_n,
  input  logic [RANKS-1:0]  in_cs_n,
  input  logic [RANKS-1:0]  in_cke,
  input  logic [RANKS-1:0]  in_odt,
  input  logic              cfg_mirror_en,
  input  logic              cfg_parity_en,
  input  logic [CADJ_W-1:0] cfg_ctl_adj,
  input  logic              err_clr,
  input  logic              par_err_n,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BANK_W-1:0] out_bank,
  output logic              out_ras_n,
  output logic              out_cas_n,
  output logic              out_we_n,
  output logic [RANKS-1:0]  out_cs_n,
  output logic [RANKS-1:0]  out_cke,
  output logic [RANKS-1:0]  out_odt,
  output logic              out_par,
  output logic              par_err_sticky,
  output logic              cfg_err
);
  localparam int MIN_ADDR_W = MIR_ADDR_TOP + 1;

  if (ADDR_W < MIN_ADDR_W || BANK_W < 2 || SYNC_STAGES < 2) begin : g_bad_param
    initial $error("ddr3_ca_mirror_parity: parameter out of range");
  end

  strobe_t           in_strb;
  logic [ADDR_W-1:0] m_addr;
  logic [BANK_W-1:0] m_bank;
  logic              m_hit;
  logic              par_d;
  logic              cfg_err_d;

  assign in_strb = '{ras_n: in_ras_n, cas_n: in_cas_n, we_n: in_we_n};

  ddr3_ca_mirror_map #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RANKS(RANKS)
  ) u_mirror (
    .mirror_en (cfg_mirror_en),
    .cs_n      (in_cs_n),
    .addr_i    (in_addr),
    .bank_i    (in_bank),
    .addr_o    (m_addr),
    .bank_o    (m_bank),
    .mirrored  (m_hit)
  );

  // Parity is taken on the post-mirror values, i.e. what the pins will carry.
  ddr3_ca_parity_gen #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_parity (
    .enable  (cfg_parity_en),
    .addr    (m_addr),
    .bank    (m_bank),
    .strobes (in_strb),
    .par     (par_d)
  );

  ddr3_ca_err_capture #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_err (
    .clk         (clk),
    .rst         (rst),
    .enable      (cfg_parity_en),
    .clr         (err_clr),
    .err_n_async (par_err_n),
    .sticky      (par_err_sticky)
  );

  assign cfg_err_d = cfg_parity_en & (|cfg_ctl_adj);

  strobe_t out_strb;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr <= '0;
      out_bank <= '0;
      out_strb <= STROBE_IDLE;
      out_cs_n <= '1;
      out_cke  <= '0;
      out_odt  <= '0;
      out_par  <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      out_addr <= m_addr;
      out_bank <= m_bank;
      out_strb <= in_strb;
      out_cs_n <= in_cs_n;
      out_cke  <= in_cke;
      out_odt  <= in_odt;
      out_par  <= par_d;
      cfg_err  <= cfg_err_d;
    end
  end

  assign out_ras_n = out_strb.ras_n;
  assign out_cas_n = out_strb.cas_n;
  assign out_we_n  = out_strb.we_n;

  logic unused_hit;
  assign unused_hit = m_hit;
endmodule

// File: rtl/ddr3_ca_mirror_parity_chk.sv
module ddr3_ca_mirror_parity_chk #(
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 3,
  parameter int RANKS       = 4,
  parameter int CADJ_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] in_addr,
  input logic [BANK_W-1:0] in_bank,
  input logic              in_ras_n,
  input logic              in_cas_n,
  input logic              in_we_n,
  input logic [RANKS-1:0]  in_cs_n,
  input logic [RANKS-1:0]  in_cke,
  input logic [RANKS-1:0]  in_odt,
  input logic              cfg_mirror_en,
  input logic              cfg_parity_en,
  input logic [CADJ_W-1:0] cfg_ctl_adj,
  input logic              err_clr,
  input logic              par_err_n,
  input logic [ADDR_W-1:0] out_addr,
  input logic [BANK_W-1:0] out_bank,
  input logic              out_ras_n,
  input logic              out_cas_n,
  input logic              out_we_n,
  input logic [RANKS-1:0]  out_cs_n,
  input logic [RANKS-1:0]  out_cke,
  input logic [RANKS-1:0]  out_odt,
  input logic              out_par,
  input logic              par_err_sticky,
  input logic              cfg_err
);
  logic odd_sel;
  assign odd_sel = cfg_mirror_en & (~in_cs_n[1] | ~in_cs_n[3]);

  a_r1_ctrl_latency: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_cs_n == $past(in_cs_n)) && (out_cke == $past(in_cke)) &&
             (out_odt == $past(in_odt)) && (out_ras_n == $past(in_ras_n)) &&
             (out_cas_n == $past(in_cas_n)) && (out_we_n == $past(in_we_n)));

  a_r2_mirror_swap: assert property (@(posedge clk) disable iff (rst)
    odd_sel |=> (out_bank[0] == $past(in_bank[1])) && (out_bank[1] == $past(in_bank[0])) &&
                (out_addr[3] == $past(in_addr[4])) && (out_addr[4] == $past(in_addr[3])) &&
                (out_addr[5] == $past(in_addr[6])) && (out_addr[6] == $past(in_addr[5])) &&
                (out_addr[7] == $past(in_addr[8])) && (out_addr[8] == $past(in_addr[7])) &&
                (out_addr[2:0] == $past(in_addr[2:0])) &&
                (out_addr[ADDR_W-1:9] == $past(in_addr[ADDR_W-1:9])));

  a_r3_passthrough: assert property (@(posedge clk) disable iff (rst)
    !odd_sel |=> (out_addr == $past(in_addr)) && (out_bank == $past(in_bank)));

  a_r4_even_parity: assert property (@(posedge clk) disable iff (rst)
    cfg_parity_en |=> ((^{out_addr, out_bank, out_ras_n, out_cas_n, out_we_n, out_par}) == 1'b0));

  a_r6_parity_off: assert property (@(posedge clk) disable iff (rst)
    !cfg_parity_en |=> (out_par == 1'b0));

  a_r7_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    (par_err_sticky && !err_clr) |=> par_err_sticky);

  a_r8_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err_sticky) |-> $past(cfg_parity_en));

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (err_clr && par_err_n && $past(par_err_n) && $past(par_err_n, 2)) |=> !par_err_sticky);

  a_r10_cfg_conflict: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cfg_err == ($past(cfg_parity_en) && ($past(cfg_ctl_adj) != '0))));

  a_r11_reset_outputs: assert property (@(posedge clk)
    rst |=> (out_cs_n == '1) && !out_par && !par_err_sticky && !cfg_err);
endmodule

bind ddr3_ca_mirror_parity ddr3_ca_mirror_parity_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RANKS(RANKS),
  .CADJ_W(CADJ_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/ddr3_ca_mirror_parity_tb.sv
module ddr3_ca_mirror_parity_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] in_addr;
  logic [2:0]  in_bank;
  logic        in_ras_n, in_cas_n, in_we_n;
  logic [3:0]  in_cs_n, in_cke, in_odt;
  logic        cfg_mirror_en, cfg_parity_en;
  logic [2:0]  cfg_ctl_adj;
  logic        err_clr, par_err_n;
  logic [15:0] out_addr;
  logic [2:0]  out_bank;
  logic        out_ras_n, out_cas_n, out_we_n;
  logic [3:0]  out_cs_n, out_cke, out_odt;
  logic        out_par, par_err_sticky, cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  ddr3_ca_mirror_parity u_dut (
    .clk, .rst, .in_addr, .in_bank, .in_ras_n, .in_cas_n, .in_we_n,
    .in_cs_n, .in_cke, .in_odt, .cfg_mirror_en, .cfg_parity_en, .cfg_ctl_adj,
    .err_clr, .par_err_n, .out_addr, .out_bank, .out_ras_n, .out_cas_n,
    .out_we_n, .out_cs_n, .out_cke, .out_odt, .out_par, .par_err_sticky, .cfg_err
  );

  function automatic bit mir_sel(input logic [3:0] cs_n, input logic men);
    return men && (!cs_n[1] || !cs_n[3]);
  endfunction

  function automatic logic [18:0] exp_ab(input logic [15:0] a, input logic [2:0] b,
                                         input logic [3:0] cs_n, input logic men);
    logic [15:0] ra = a;
    logic [2:0]  rb = b;
    if (mir_sel(cs_n, men)) begin
      ra[3] = a[4]; ra[4] = a[3];
      ra[5] = a[6]; ra[6] = a[5];
      ra[7] = a[8]; ra[8] = a[7];
      rb[0] = b[1]; rb[1] = b[0];
    end
    return {rb, ra};
  endfunction

  function automatic logic exp_par(input logic [18:0] ab, input logic r, c, w, pen);
    return pen ? ^{ab, r, c, w} : 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic drive_cmd(input logic [15:0] a, input logic [2:0] b, input logic [2:0] strb,
                           input logic [3:0] cs, input logic [3:0] ck, input logic [3:0] od);
    in_addr = a; in_bank = b;
    {in_ras_n, in_cas_n, in_we_n} = strb;
    in_cs_n = cs; in_cke = ck; in_odt = od;
  endtask

  task automatic check_cmd(input logic [15:0] a, input logic [2:0] b, input logic [2:0] strb,
                           input logic [3:0] cs, input logic [3:0] ck, input logic [3:0] od,
                           input logic men, input logic pen, input string rq_ab);
    logic [18:0] e = exp_ab(a, b, cs, men);
    logic        ep = exp_par(e, strb[2], strb[1], strb[0], pen);
    chk({out_bank, out_addr} == e, rq_ab, {13'd0, out_bank, out_addr}, {13'd0, e});
    chk({out_cs_n, out_cke, out_odt, out_ras_n, out_cas_n, out_we_n} == {cs, ck, od, strb},
        "R1", {17'd0, out_cs_n, out_cke, out_odt, out_ras_n, out_cas_n, out_we_n},
        {17'd0, cs, ck, od, strb});
    chk(out_par == ep, pen ? "R4" : "R6", {31'd0, out_par}, {31'd0, ep});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    drive_cmd(16'hFFFF, 3'b111, 3'b000, 4'b0000, 4'hF, 4'hF);
    cfg_mirror_en = 1'b1; cfg_parity_en = 1'b1; cfg_ctl_adj = 3'd2;
    err_clr = 1'b0; par_err_n = 1'b1;
    repeat (3) tick();
    // R11: reset state while inputs are active
    chk(out_cs_n == 4'hF && out_ras_n && out_cas_n && out_we_n, "R11",
        {28'd0, out_cs_n}, 32'hF);
    chk(out_addr == 16'd0 && out_bank == 3'd0 && out_cke == 4'd0 && out_odt == 4'd0 && !out_par,
        "R11", {13'd0, out_bank, out_addr}, 32'd0);
    chk(!par_err_sticky && !cfg_err, "R11", {30'd0, par_err_sticky, cfg_err}, 32'd0);
    rst = 1'b0;

    // Random traffic with random configuration; error line idle high.
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a  = 16'($urandom);
      logic [2:0]  b  = 3'($urandom);
      logic [2:0]  s  = 3'($urandom);
      logic [3:0]  cs = 4'($urandom);
      logic [3:0]  ck = 4'($urandom);
      logic [3:0]  od = 4'($urandom);
      logic        men = 1'($urandom);
      logic        pen = 1'($urandom);
      logic [2:0]  adj = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
      drive_cmd(a, b, s, cs, ck, od);
      cfg_mirror_en = men; cfg_parity_en = pen; cfg_ctl_adj = adj;
      tick();
      check_cmd(a, b, s, cs, ck, od, men, pen, mir_sel(cs, men) ? "R2" : "R3");
      chk(cfg_err == (pen && adj != 0), "R10", {31'd0, cfg_err}, {31'd0, pen && adj != 0});
      chk(!par_err_sticky, "R7", {31'd0, par_err_sticky}, 32'd0);
    end

    // R2 directed: rank 1, bit 3 and bank bit 0 move up.
    cfg_mirror_en = 1'b1; cfg_parity_en = 1'b1; cfg_ctl_adj = 3'd0;
    drive_cmd(16'h0008, 3'b001, 3'b011, 4'b1101, 4'hF, 4'h0);
    tick();
    chk(out_addr == 16'h0010 && out_bank == 3'b010, "R2", {13'd0, out_bank, out_addr}, 32'h20010);
    // R2 directed: rank 3, bits 8,7,5 become 8,7,6.
    drive_cmd(16'h01A0, 3'b110, 3'b101, 4'b0111, 4'hF, 4'h0);
    tick();
    chk(out_addr == 16'h01C0 && out_bank == 3'b101, "R2", {13'd0, out_bank, out_addr}, 32'h501C0);
    // R3 directed: rank 2 with mirroring on stays unswapped.
    drive_cmd(16'h0008, 3'b001, 3'b011, 4'b1011, 4'hF, 4'h0);
    tick();
    chk(out_addr == 16'h0008 && out_bank == 3'b001, "R3", {13'd0, out_bank, out_addr}, 32'h10008);
    // R3 directed: rank 1 with mirroring off stays unswapped.
    cfg_mirror_en = 1'b0;
    drive_cmd(16'h0008, 3'b001, 3'b011, 4'b1101, 4'hF, 4'h0);
    tick();
    chk(out_addr == 16'h0008 && out_bank == 3'b001, "R3", {13'd0, out_bank, out_addr}, 32'h10008);

    // R5: fixed command, varying CS (even ranks), CKE, ODT; parity must not move.
    begin
      logic ep = exp_par(exp_ab(16'h1234, 3'b101, 4'b1110, 1'b0), 1'b0, 1'b1, 1'b0, 1'b1);
      cfg_parity_en = 1'b1;
      for (int k = 0; k < 8; k++) begin
        logic [3:0] cs = (k % 2 == 0) ? 4'b1110 : 4'b1011;
        drive_cmd(16'h1234, 3'b101, 3'b010, cs, 4'(k * 5), 4'(k * 3 + 1));
        tick();
        chk(out_par == ep, "R5", {31'd0, out_par}, {31'd0, ep});
      end
      // R6: same command with parity off gives zero.
      cfg_parity_en = 1'b0;
      tick();
      chk(out_par == 1'b0, "R6", {31'd0, out_par}, 32'd0);
    end

    // R8: fault held low with parity disabled leaves no trace.
    cfg_parity_en = 1'b0;
    par_err_n = 1'b0;
    repeat (6) tick();
    chk(!par_err_sticky, "R8", {31'd0, par_err_sticky}, 32'd0);
    par_err_n = 1'b1;
    repeat (4) tick();
    cfg_parity_en = 1'b1;
    repeat (4) tick();
    chk(!par_err_sticky, "R8", {31'd0, par_err_sticky}, 32'd0);

    // R7: a single low sample sets the flag within three edges and it stays.
    par_err_n = 1'b0;
    tick();
    par_err_n = 1'b1;
    tick();
    chk(!par_err_sticky, "R7", {31'd0, par_err_sticky}, 32'd0);
    tick();
    chk(par_err_sticky, "R7", {31'd0, par_err_sticky}, 32'd1);
    repeat (5) tick();
    chk(par_err_sticky, "R7", {31'd0, par_err_sticky}, 32'd1);

    // R9: clear pulse with the line idle.
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;
    chk(!par_err_sticky, "R9", {31'd0, par_err_sticky}, 32'd0);
    // R9: fault held low wins over a clear pulse.
    par_err_n = 1'b0;
    repeat (4) tick();
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;
    chk(par_err_sticky, "R9", {31'd0, par_err_sticky}, 32'd1);
    par_err_n = 1'b1;
    repeat (4) tick();
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;
    chk(!par_err_sticky, "R9", {31'd0, par_err_sticky}, 32'd0);

    // R10 directed.
    cfg_parity_en = 1'b1; cfg_ctl_adj = 3'd4;
    tick();
    chk(cfg_err, "R10", {31'd0, cfg_err}, 32'd1);
    cfg_parity_en = 1'b0;
    tick();
    chk(!cfg_err, "R10", {31'd0, cfg_err}, 32'd0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule